// File: doc/BRIEF.md
# Master-Clock Ratio and Bit-Clock Source Detector

This block sits on the master clock of an audio converter's serial input and works out how the incoming stream is clocked. It counts master clocks between rising edges of the frame (left/right) clock and sorts the count into a base-rate or a high-rate oversampling mode. A count that is not one of the five legal ratios raises an error that can drive an external mute.

It also decides where the serial bit clock comes from. A burst of rising edges on the bit-clock pin within one frame-clock phase switches to external mode. Two whole frame periods without any edge switch back to internal mode. In internal mode the block generates a bit clock itself. This clock is a power-of-two tap of a master-clock phase counter that restarts at every frame-clock edge. Its rate depends on the measured ratio and on the serial data format.

While the bit clock is internal, the bit-clock pin is a static control level and becomes the upper bit of the de-emphasis selection. The block outputs a de-emphasis code that is valid for the current clock mode and rate mode.

Top module: `rt_clkmode_det`

## Requirements
- R1: The ratio is the number of master-clock cycles from one sampled rising frame-clock edge to the next. The rate mode and the error flag change only in the cycle after a rising frame-clock edge. The first rising edge after reset only starts the count.
- R2: A measured ratio of 256, 384 or 512 sets `hi_rate` to 0. A measured ratio of 128 or 192 sets `hi_rate` to 1.
- R3: Any other measured count sets `ratio_err` to 1 and leaves `hi_rate` and the divider selection unchanged. `ratio_err` is 1 from reset until the first legal measurement.
- R4: For ratios 384 and 192 the internal bit clock runs at 48 times the frame rate, whatever the format. Its period is ratio/48 master clocks.
- R5: For ratios 512, 256 and 128, formats 0 (I2S) and 3 (right-justified 16-bit) give 32 bit clocks per frame. Formats 1 (left-justified) and 2 (right-justified 24-bit) give 64 bit clocks per frame. The format is the 2-bit `fmt` input.
- R6: The internal bit clock is low for the first half-period after every frame-clock edge (rising or falling). It is held low while `ratio_err` is 1.
- R7: The bit-clock pin passes through a 2-stage synchroniser and then a rising-edge detector. `ext_mode` goes to 1 in the cycle after the 16th detected rising edge within one frame-clock phase. An edge detected in the same cycle as a frame-clock edge counts for the new phase.
- R8: `ext_mode` returns to 0 after two consecutive rising-to-rising frame periods in which no bit-clock edge was detected. An edge detected in the same cycle as the closing frame-clock rise belongs to the period that is closing.
- R9: In internal mode at base rate, `demph` is {synchronised bit-clock pin level, `dsel_lo`}. The codes are 00 off, 01 44.1 kHz, 10 48 kHz and 11 32 kHz.
- R10: In external mode at base rate, `demph` is {0, `dsel_lo`}, so only off or 44.1 kHz can be selected.
- R11: In high-rate mode, `demph` is 00.
- R12: During reset the outputs are `hi_rate`=0, `ratio_err`=1, `ext_mode`=0, `ibck`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm | input | 1 | Frame clock, synchronous to `clk` |
| bck | input | 1 | Bit-clock pin, or upper de-emphasis select in internal mode |
| fmt | input | 2 | Serial format: 0 I2S, 1 left-justified, 2 right-justified 24, 3 right-justified 16 |
| dsel_lo | input | 1 | Lower de-emphasis select |
| hi_rate | output | 1 | 1 = high-rate mode |
| ratio_err | output | 1 | Unsupported or not yet measured ratio |
| ext_mode | output | 1 | 1 = external bit clock in use |
| ibck | output | 1 | Internally generated bit clock |
| demph | output | 2 | De-emphasis code |

## Verification
The bench uses the default parameters: a 10-bit ratio counter, a 2-stage synchroniser, a 16-edge entry threshold and a 2-frame idle exit. With these values, every legal ratio, one illegal ratio (300) and the transient illegal counts between frames of different lengths can be reached within a short run. Bit-clock bursts of exactly 15 and 16 edges per phase test the entry threshold at its boundary. A burst that is present only in one phase of each frame shows that the exit needs whole silent frame periods. A behavioural model predicts every output on every cycle, including high-rate frames that carry an external bit clock.

// File: rtl/rt_clkmode_pkg.sv
package rt_clkmode_pkg;

   localparam int unsigned FR_128 = 128;
   localparam int unsigned FR_192 = 192;
   localparam int unsigned FR_256 = 256;
   localparam int unsigned FR_384 = 384;
   localparam int unsigned FR_512 = 512;

   typedef enum logic [2:0] {
      RAT_NONE = 3'd0,
      RAT_128  = 3'd1,
      RAT_192  = 3'd2,
      RAT_256  = 3'd3,
      RAT_384  = 3'd4,
      RAT_512  = 3'd5
   } ratio_e;

   typedef enum logic [1:0] {
      FMT_I2S  = 2'd0,
      FMT_LJ   = 2'd1,
      FMT_RJ24 = 2'd2,
      FMT_RJ16 = 2'd3
   } fmt_e;

   // Tap of the phase counter that yields the bit clock: period = 2^(tap+1)
   function automatic logic [1:0] div_tap(ratio_e r, logic [1:0] f);
      logic wide;
      wide = (fmt_e'(f) == FMT_LJ) || (fmt_e'(f) == FMT_RJ24);
      case (r)
         RAT_512: return wide ? 2'd2 : 2'd3;
         RAT_384: return 2'd2;
         RAT_256: return wide ? 2'd1 : 2'd2;
         RAT_192: return 2'd1;
         RAT_128: return wide ? 2'd0 : 2'd1;
         default: return 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/rt_ratio_meter.sv
module rt_ratio_meter
   import rt_clkmode_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   frm_rise,
   output ratio_e ratio,
   output logic   hi_rate,
   output logic   ratio_err
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   generate
      if (CNT_W < 10) begin : g_bad_width
         $error("rt_ratio_meter: CNT_W must reach a ratio of 512");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic             seen;
   ratio_e           meas;

   always_comb begin
      if      (cnt == CNT_W'(FR_128)) meas = RAT_128;
      else if (cnt == CNT_W'(FR_192)) meas = RAT_192;
      else if (cnt == CNT_W'(FR_256)) meas = RAT_256;
      else if (cnt == CNT_W'(FR_384)) meas = RAT_384;
      else if (cnt == CNT_W'(FR_512)) meas = RAT_512;
      else                            meas = RAT_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         seen      <= 1'b0;
         ratio     <= RAT_NONE;
         hi_rate   <= 1'b0;
         ratio_err <= 1'b1;
      end else if (frm_rise) begin
         cnt  <= CNT_W'(1);
         seen <= 1'b1;
         if (seen) begin
            if (meas != RAT_NONE) begin
               ratio     <= meas;
               hi_rate   <= (meas == RAT_128) || (meas == RAT_192);
               ratio_err <= 1'b0;
            end else begin
               ratio_err <= 1'b1;
            end
         end
      end else if (cnt != CNT_MAX) begin
         cnt <= cnt + CNT_W'(1);
      end
   end

endmodule

// File: rtl/rt_bclk_gen.sv
module rt_bclk_gen
   import rt_clkmode_pkg::*;
#(
   parameter int PC_W = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frm_edge,
   input  ratio_e     ratio,
   input  logic [1:0] fmt,
   input  logic       run,
   output logic       ibck
);

   generate
      if (PC_W < 4) begin : g_bad_width
         $error("rt_bclk_gen: PC_W must cover the widest tap");
      end
   endgenerate

   logic [PC_W-1:0] pc;
   logic [1:0]      tap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pc <= '0;
      else if (frm_edge) pc <= '0;
      else               pc <= pc + PC_W'(1);
   end

   assign tap  = div_tap(ratio, fmt);
   assign ibck = run & pc[tap];

endmodule

// File: rtl/rt_bclk_src.sv
module rt_bclk_src #(
   parameter int EDGE_CNT    = 16,
   parameter int IDLE_FRAMES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frm_edge,
   input  logic frm_rise,
   input  logic bck_rise,
   output logic ext_mode
);

   localparam int EW = $clog2(EDGE_CNT + 1);
   localparam int IW = $clog2(IDLE_FRAMES + 1);
   localparam logic [EW-1:0] E_TOP  = EW'(EDGE_CNT);
   localparam logic [EW-1:0] E_LAST = EW'(EDGE_CNT - 1);
   localparam logic [IW-1:0] I_TOP  = IW'(IDLE_FRAMES);
   localparam logic [IW-1:0] I_LAST = IW'(IDLE_FRAMES - 1);

   generate
      if (EDGE_CNT < 2 || IDLE_FRAMES < 1) begin : g_bad_cfg
         $error("rt_bclk_src: EDGE_CNT >= 2 and IDLE_FRAMES >= 1 required");
      end
   endgenerate

   logic [EW-1:0] ecnt;
   logic [IW-1:0] idle;
   logic          act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ecnt     <= '0;
         idle     <= '0;
         act      <= 1'b0;
         ext_mode <= 1'b0;
      end else begin
         if (frm_edge)                       ecnt <= bck_rise ? EW'(1) : '0;
         else if (bck_rise && ecnt != E_TOP) ecnt <= ecnt + EW'(1);

         if (frm_rise) begin
            act <= 1'b0;
            if (act || bck_rise)    idle <= '0;
            else if (idle != I_TOP) idle <= idle + IW'(1);
         end else if (bck_rise) begin
            act <= 1'b1;
         end

         if (bck_rise && !frm_edge && ecnt == E_LAST)
            ext_mode <= 1'b1;
         else if (frm_rise && !act && !bck_rise && idle == I_LAST)
            ext_mode <= 1'b0;
      end
   end

endmodule

// File: rtl/rt_clkmode_det.sv
module rt_clkmode_det
   import rt_clkmode_pkg::*;
#(
   parameter int CNT_W       = 10,
   parameter int SYNC_STAGES = 2,
   parameter int EDGE_CNT    = 16,
   parameter int IDLE_FRAMES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frm,
   input  logic       bck,
   input  logic [1:0] fmt,
   input  logic       dsel_lo,
   output logic       hi_rate,
   output logic       ratio_err,
   output logic       ext_mode,
   output logic       ibck,
   output logic [1:0] demph
);

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("rt_clkmode_det: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic                   frm_d;
   logic                   frm_rise;
   logic                   frm_edge;
   logic [SYNC_STAGES-1:0] bsync;
   logic                   bck_s;
   logic                   bck_d;
   logic                   bck_rise;
   ratio_e                 ratio;

   generate
      if (SYNC_STAGES == 1) begin : g_sync_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bsync <= '0;
            else        bsync <= bck;
         end
      end else begin : g_sync_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bsync <= '0;
            else        bsync <= {bsync[SYNC_STAGES-2:0], bck};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frm_d <= 1'b0;
         bck_d <= 1'b0;
      end else begin
         frm_d <= frm;
         bck_d <= bck_s;
      end
   end

   assign bck_s    = bsync[SYNC_STAGES-1];
   assign bck_rise = bck_s & ~bck_d;
   assign frm_rise = frm & ~frm_d;
   assign frm_edge = frm ^ frm_d;

   rt_ratio_meter #(.CNT_W(CNT_W)) u_meter (
      .clk       (clk),
      .rst_n     (rst_n),
      .frm_rise  (frm_rise),
      .ratio     (ratio),
      .hi_rate   (hi_rate),
      .ratio_err (ratio_err)
   );

   rt_bclk_gen #(.PC_W(CNT_W)) u_gen (
      .clk      (clk),
      .rst_n    (rst_n),
      .frm_edge (frm_edge),
      .ratio    (ratio),
      .fmt      (fmt),
      .run      (~ratio_err),
      .ibck     (ibck)
   );

   rt_bclk_src #(.EDGE_CNT(EDGE_CNT), .IDLE_FRAMES(IDLE_FRAMES)) u_src (
      .clk      (clk),
      .rst_n    (rst_n),
      .frm_edge (frm_edge),
      .frm_rise (frm_rise),
      .bck_rise (bck_rise),
      .ext_mode (ext_mode)
   );

   always_comb begin
      if (hi_rate)       demph = 2'b00;
      else if (ext_mode) demph = {1'b0, dsel_lo};
      else               demph = {bck_s, dsel_lo};
   end

endmodule

// File: rtl/rt_clkmode_chk.sv
module rt_clkmode_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       frm_rise,
   input logic       frm_edge,
   input logic       bck_rise,
   input logic       hi_rate,
   input logic       ratio_err,
   input logic       ext_mode,
   input logic       ibck,
   input logic [1:0] demph
);

   AST_MODE_ONLY_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(frm_rise) |-> ($stable(hi_rate) && $stable(ratio_err))); // R1

   AST_IBCK_QUIET_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_err |-> !ibck); // R6

   AST_IBCK_LOW_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      frm_edge |=> !ibck); // R6

   AST_EXT_ENTRY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_mode) |-> ($past(bck_rise) && !$past(frm_edge))); // R7

   AST_EXT_EXIT_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ext_mode) |-> ($past(frm_rise) && !$past(bck_rise))); // R8

   AST_HIRATE_DEEMPH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      hi_rate |-> (demph == 2'b00)); // R11

   AST_EXT_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ext_mode |-> !demph[1]); // R10

endmodule

bind rt_clkmode_det rt_clkmode_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .frm_rise  (frm_rise),
   .frm_edge  (frm_edge),
   .bck_rise  (bck_rise),
   .hi_rate   (hi_rate),
   .ratio_err (ratio_err),
   .ext_mode  (ext_mode),
   .ibck      (ibck),
   .demph     (demph)
);

// File: tb/sim_rt_clkmode_det.sv
module sim_rt_clkmode_det;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frm = 1'b0;
   logic       bck = 1'b0;
   logic [1:0] fmt = 2'd0;
   logic       dsel_lo = 1'b0;
   logic       hi_rate, ratio_err, ext_mode, ibck;
   logic [1:0] demph;

   int n_cmp = 0;
   int n_bad = 0;

   rt_clkmode_det u0 (
      .clk(clk), .rst_n(rst_n), .frm(frm), .bck(bck), .fmt(fmt),
      .dsel_lo(dsel_lo), .hi_rate(hi_rate), .ratio_err(ratio_err),
      .ext_mode(ext_mode), .ibck(ibck), .demph(demph)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural reference state
   int cyc = 0;
   int last_rise = -1;
   int last_edge = 0;
   int m_ratio = 0;
   bit m_err = 1'b1;
   bit m_hi = 1'b0;
   bit m_ext = 1'b0;
   int ph = 0;
   int idle = 0;
   bit act = 1'b0;
   bit fp = 1'b0;
   bit h1 = 1'b0, h2 = 1'b0, h3 = 1'b0;

   function automatic bit legal(int p);
      return p == 128 || p == 192 || p == 256 || p == 384 || p == 512;
   endfunction

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      bit rf, ef, rb;
      cyc++;
      if (cyc > WATCHDOG) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: run did not end, actual cycles %0d expected < %0d", cyc, WATCHDOG);
         finish_run();
      end
      if (!rst_n) begin
         last_rise = -1; last_edge = cyc; m_ratio = 0; m_err = 1; m_hi = 0;
         m_ext = 0; ph = 0; idle = 0; act = 0; fp = 0; h1 = 0; h2 = 0; h3 = 0;
      end else begin
         rf = frm && !fp;
         ef = frm != fp;
         rb = h2 && !h3;
         if (rf) begin
            if (last_rise >= 0) begin
               if (legal(cyc - last_rise)) begin
                  m_ratio = cyc - last_rise;
                  m_hi = (m_ratio < 256);
                  m_err = 0;
               end else m_err = 1;
            end
            last_rise = cyc;
         end
         if (ef) last_edge = cyc;
         if (ef) ph = rb ? 1 : 0;
         else if (rb) begin
            if (ph == 15) m_ext = 1;
            ph++;
         end
         if (rf) begin
            if (!act && !rb) begin
               if (idle == 1) m_ext = 0;
               idle++;
            end else idle = 0;
            act = 0;
         end else if (rb) act = 1;
         fp = frm; h3 = h2; h2 = h1; h1 = bck;
      end
   end

   task automatic cmp(string tag, int act_v, int exp_v);
      n_cmp++;
      if (act_v != exp_v) begin
         n_bad++;
         $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act_v, exp_v);
      end
   endtask

   function automatic int exp_ibck();
      int bits, n, sh;
      if (m_err) return 0;
      bits = (m_ratio == 384 || m_ratio == 192) ? 48 : ((fmt == 0 || fmt == 3) ? 32 : 64);
      n = m_ratio / bits;
      sh = $clog2(n) - 1;
      return (((cyc - last_edge) % 1024) >> sh) & 1;
   endfunction

   function automatic int exp_demph();
      if (m_hi) return 0;
      if (m_ext) return int'(dsel_lo);
      return int'({h2, dsel_lo});
   endfunction

   task automatic compare_all();
      cmp("R1/R2 hi_rate", int'(hi_rate), int'(m_hi));
      cmp("R3 ratio_err", int'(ratio_err), int'(m_err));
      cmp("R7/R8 ext_mode", int'(ext_mode), int'(m_ext));
      cmp("R4/R5/R6 ibck", int'(ibck), exp_ibck());
      cmp("R9/R10/R11 demph", int'(demph), exp_demph());
   endtask

   task automatic tick(bit f, bit b, logic [1:0] fm, bit ds);
      @(negedge clk);
      compare_all();
      frm = f; bck = b; fmt = fm; dsel_lo = ds;
   endtask

   // mode 0: static level; 1: nr rises in every phase; 2: nr rises in high phase only
   task automatic frames(int p, int n, logic [1:0] fm, bit ds, int mode, int nr, bit lvl);
      for (int fr = 0; fr < n; fr++) begin
         for (int pos = 0; pos < p; pos++) begin
            bit fv, bv;
            int q;
            fv = (pos >= p/2);
            q = pos % (p/2);
            if (mode == 0) bv = lvl;
            else if (mode == 2 && !fv) bv = 1'b0;
            else bv = (q >= 2 && q < 2 + 4*nr) ? (((q - 2) % 4) < 2) : 1'b0;
            tick(fv, bv, fm, ds);
         end
      end
   endtask

   initial begin
      for (int i = 0; i < 4; i++) tick(1'b0, 1'b1, 2'd0, 1'b1);
      // R12: reset values
      cmp("R12 reset hi_rate", int'(hi_rate), 0);
      cmp("R12 reset ratio_err", int'(ratio_err), 1);
      cmp("R12 reset ext_mode", int'(ext_mode), 0);
      cmp("R12 reset ibck", int'(ibck), 0);
      rst_n = 1'b1;
      frames(512, 4, 2'd0, 1'b0, 0, 0, 1'b1);   // R2 R5 R9: base rate, 32x, 48 kHz code
      frames(512, 3, 2'd1, 1'b1, 0, 0, 1'b0);   // R5: 64x
      frames(384, 4, 2'd2, 1'b1, 0, 0, 1'b1);   // R4: 48x
      frames(256, 4, 2'd3, 1'b0, 0, 0, 1'b0);   // R5
      frames(256, 3, 2'd2, 1'b1, 0, 0, 1'b1);   // R5
      frames(128, 4, 2'd1, 1'b1, 0, 0, 1'b1);   // R2 R11: high rate
      frames(128, 3, 2'd0, 1'b0, 0, 0, 1'b1);
      frames(192, 4, 2'd0, 1'b0, 0, 0, 1'b1);   // R4
      frames(300, 3, 2'd0, 1'b1, 0, 0, 1'b1);   // R3: illegal, mode held
      frames(256, 3, 2'd1, 1'b1, 0, 0, 1'b0);   // R3: recovery
      frames(256, 3, 2'd1, 1'b1, 1, 15, 1'b0);  // R7: 15 edges, stays internal
      frames(256, 3, 2'd1, 1'b1, 1, 16, 1'b0);  // R7: 16 edges, external
      frames(256, 2, 2'd0, 1'b0, 1, 30, 1'b0);  // R10
      frames(256, 3, 2'd1, 1'b1, 2, 16, 1'b0);  // R8: one silent phase, stays external
      frames(256, 4, 2'd1, 1'b1, 0, 0, 1'b1);   // R8: silent, back to internal
      frames(128, 3, 2'd0, 1'b1, 1, 16, 1'b0);  // R11: external in high rate
      frames(512, 3, 2'd3, 1'b1, 0, 0, 1'b1);   // R8 R9
      finish_run();
   end

endmodule